// File: doc/BRIEF.md
# Bus Arbiter with Complete-Lock Reservation

This block decides which of several bus masters may start the next transaction. Each agent raises its own request line and receives its own grant line. A cache agent has a separate writeback request and grant. The arbiter watches the bus transaction indicator (FRAME, active high here) and the bus lock indicator (LOCK, active high here). Grants are re-evaluated only while the bus is idle. The grant chosen on an idle cycle is held for the whole of the transaction that follows.

A mode input selects how the lock is treated. In ordinary arbitration the lock has no effect: requesting agents are served round-robin, and the latest grantee moves to the lowest priority. In complete-lock mode, a master takes ownership of the lock when LOCK rises while that master is granted and a transaction is under way. While ownership stands and LOCK stays high, only that master can be granted. The one exception is a writeback that a snoop forces on the cache. That writeback wins for a single transaction, after which the bus goes back to the lock owner.

Top module: `bus_lock_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, no grant output is high and no lock owner is recorded. After reset, agent 0 has the highest round-robin priority.
- R2: In every cycle, at most one of the agent grants and the writeback grant is high.
- R3: The grants are updated only at clock edges where frameActive is low. At an edge where frameActive is high, all grants keep their values.
- R4: When no restriction applies, the grant at an idle edge goes to the first requesting agent found in increasing index order, counting from the agent after the last one granted and wrapping around. If no agent is requesting, no grant is given.
- R5: An agent becomes lock owner only at an edge where lockActive is high, lockActive was low at the previous edge, frameActive is high, no owner is recorded yet, and that agent's grant is high. A grant held while LOCK rises on an idle bus confers no ownership.
- R6: With lockMode=1, an owner recorded and lockActive high at an idle edge, the owner's grant is the only agent grant possible. If the owner is not requesting, no agent grant is given.
- R7: With lockMode=0, the lock and the lock owner have no effect on grant selection, which follows R4.
- R8: At an idle edge, a writeback request that is not blocked takes the writeback grant ahead of every agent, in both modes and during a lock.
- R9: A writeback grant covers one transaction. Once the writeback grant has been high at an edge with frameActive high, the writeback request is ignored until it has been deasserted. Arbitration then falls through to the lock owner, or to R4.
- R10: The lock owner record clears at any edge where frameActive and lockActive are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lockMode | input | 1 | 1 = complete-lock reservation, 0 = ordinary arbitration |
| req | input | NUM_AGENTS | Per-agent bus requests |
| wbReq | input | 1 | Cache writeback request forced by a snoop hit |
| frameActive | input | 1 | High while a bus transaction is in progress |
| lockActive | input | 1 | High while the bus lock is asserted |
| gnt | output | NUM_AGENTS | Per-agent bus grants, at most one high |
| wbGnt | output | 1 | Grant for the cache writeback |

## Verification
The lock reservation and the writeback exception can act at the same idle edge: LOCK is held, an owner is recorded, and the cache raises its writeback request. This is provoked in a directed sequence and, many times over, by random stimulus that keeps LOCK high for long stretches while wbReq toggles. The result must be the writeback grant first and then the owner's grant once the writeback transaction has ended, with no third agent in between. Each cycle's grants are compared with a reference model in the bench, and every mismatch is tagged with the rule that decided that cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int IDX_W_MAX = 5;

  typedef struct packed {
    logic                 update;
    logic                 pickWb;
    logic                 pickOwner;
    logic [IDX_W_MAX-1:0] ownerIdx;
  } arbStrobes_t;
endpackage

// File: rtl/arb_lock_ctrl.sv
module arb_lock_ctrl
  import arb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lockMode,
  input  logic                 wbReq,
  input  logic                 frameActive,
  input  logic                 lockActive,
  input  logic                 grantValid,
  input  logic [IDX_W_MAX-1:0] grantIdx,
  input  logic                 wbGnt,
  output arbStrobes_t          strb
);
  logic                 lockPrev;
  logic                 ownerValid;
  logic [IDX_W_MAX-1:0] ownerIdx;
  logic                 wbBlock;
  logic                 lockRise;
  logic                 ownerClear;
  logic                 ownerTake;

  assign lockRise   = lockActive && !lockPrev;
  assign ownerClear = !frameActive && !lockActive;
  assign ownerTake  = lockRise && frameActive && grantValid && !ownerValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockPrev   <= 1'b0;
      ownerValid <= 1'b0;
      ownerIdx   <= '0;
      wbBlock    <= 1'b0;
    end else begin
      lockPrev <= lockActive;
      if (ownerClear) begin
        ownerValid <= 1'b0;
      end else if (ownerTake) begin
        ownerValid <= 1'b1;
        ownerIdx   <= grantIdx;
      end
      if (!wbReq) begin
        wbBlock <= 1'b0;
      end else if (wbGnt && frameActive) begin
        wbBlock <= 1'b1;
      end
    end
  end

  always_comb begin
    strb.update    = !frameActive;
    strb.pickWb    = wbReq && !wbBlock;
    strb.pickOwner = lockMode && ownerValid && lockActive;
    strb.ownerIdx  = ownerIdx;
  end

  // R10: owner record drops once bus and lock are both idle
  a_r10_owner_clear: assert property (@(posedge clk) disable iff (!rstN)
    (!frameActive && !lockActive) |=> !ownerValid);

  // R5: ownership goes to the agent granted at the rising lock edge
  a_r5_owner_take: assert property (@(posedge clk) disable iff (!rstN)
    ownerTake |=> (ownerValid && ownerIdx == $past(grantIdx)));

  // R5: no ownership without a transaction in flight
  a_r5_no_idle_take: assert property (@(posedge clk) disable iff (!rstN)
    (!ownerValid && !frameActive) |=> !ownerValid);
endmodule

// File: rtl/arb_grant_path.sv
module arb_grant_path
  import arb_pkg::*;
#(
  parameter int NUM_AGENTS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_AGENTS-1:0] req,
  input  arbStrobes_t           strb,
  output logic [NUM_AGENTS-1:0] gnt,
  output logic                  wbGnt,
  output logic                  grantValid,
  output logic [IDX_W_MAX-1:0]  grantIdx
);
  localparam int IDX_W = (NUM_AGENTS > 1) ? $clog2(NUM_AGENTS) : 1;
  localparam logic [IDX_W_MAX-1:0] LAST_RESET = IDX_W_MAX'(NUM_AGENTS - 1);

  logic [IDX_W_MAX-1:0]  lastIdx;
  logic                  rrFound;
  logic [IDX_W_MAX-1:0]  rrIdx;
  logic                  ownerReq;
  logic [NUM_AGENTS-1:0] nextGnt;
  logic                  nextWb;
  logic [IDX_W_MAX-1:0]  nextLast;

  always_comb begin
    rrFound = 1'b0;
    rrIdx   = '0;
    for (int k = 1; k <= NUM_AGENTS; k++) begin
      int cand;
      cand = (int'(lastIdx) + k) % NUM_AGENTS;
      if (!rrFound && req[cand]) begin
        rrFound = 1'b1;
        rrIdx   = IDX_W_MAX'(cand);
      end
    end
  end

  assign ownerReq = req[strb.ownerIdx[IDX_W-1:0]];

  always_comb begin
    nextGnt  = '0;
    nextWb   = 1'b0;
    nextLast = lastIdx;
    if (strb.pickWb) begin
      nextWb = 1'b1;
    end else if (strb.pickOwner) begin
      if (ownerReq) begin
        nextGnt  = NUM_AGENTS'(1) << strb.ownerIdx;
        nextLast = strb.ownerIdx;
      end
    end else if (rrFound) begin
      nextGnt  = NUM_AGENTS'(1) << rrIdx;
      nextLast = rrIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gnt     <= '0;
      wbGnt   <= 1'b0;
      lastIdx <= LAST_RESET;
    end else if (strb.update) begin
      gnt     <= nextGnt;
      wbGnt   <= nextWb;
      lastIdx <= nextLast;
    end
  end

  always_comb begin
    grantValid = |gnt;
    grantIdx   = '0;
    for (int i = 0; i < NUM_AGENTS; i++) begin
      if (gnt[i]) grantIdx = IDX_W_MAX'(i);
    end
  end

  // R2: a single grant at most
  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({gnt, wbGnt}));

  // R3: grants frozen while a transaction runs
  a_r3_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    !strb.update |=> ($stable(gnt) && $stable(wbGnt)));

  // R8: unblocked writeback wins the idle edge
  a_r8_wb_first: assert property (@(posedge clk) disable iff (!rstN)
    (strb.update && strb.pickWb) |=> (wbGnt && gnt == '0));

  // R6: only the owner under a complete lock
  a_r6_owner_only: assert property (@(posedge clk) disable iff (!rstN)
    (strb.update && strb.pickOwner && !strb.pickWb) |=>
      (!wbGnt && (gnt & ~(NUM_AGENTS'(1) << $past(strb.ownerIdx))) == '0));
endmodule

// File: rtl/bus_lock_arbiter.sv
module bus_lock_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_AGENTS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  lockMode,
  input  logic [NUM_AGENTS-1:0] req,
  input  logic                  wbReq,
  input  logic                  frameActive,
  input  logic                  lockActive,
  output logic [NUM_AGENTS-1:0] gnt,
  output logic                  wbGnt
);
  arbStrobes_t          strb;
  logic                 grantValid;
  logic [IDX_W_MAX-1:0] grantIdx;

  arb_lock_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lockMode   (lockMode),
    .wbReq      (wbReq),
    .frameActive(frameActive),
    .lockActive (lockActive),
    .grantValid (grantValid),
    .grantIdx   (grantIdx),
    .wbGnt      (wbGnt),
    .strb       (strb)
  );

  arb_grant_path #(.NUM_AGENTS(NUM_AGENTS)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .req       (req),
    .strb      (strb),
    .gnt       (gnt),
    .wbGnt     (wbGnt),
    .grantValid(grantValid),
    .grantIdx  (grantIdx)
  );

  // R1: nothing granted on the cycle after reset
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (gnt == '0 && !wbGnt));
endmodule

// File: tb/sim_bus_lock_arbiter.sv
`timescale 1ns/1ps
module sim_bus_lock_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         lockMode = 1'b0;
  logic [N-1:0] req = '0;
  logic         wbReq = 1'b0;
  logic         frameActive = 1'b0;
  logic         lockActive = 1'b0;
  logic [N-1:0] gnt;
  logic         wbGnt;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [N-1:0] mGnt;
  logic         mWb;
  logic         mOwnV;
  int           mOwn;
  int           mLast;
  logic         mLockPrev;
  logic         mWbBlk;
  string        mTag;

  always #10 clk = ~clk;

  bus_lock_arbiter #(.NUM_AGENTS(N)) u0 (
    .clk(clk), .rstN(rstN), .lockMode(lockMode), .req(req), .wbReq(wbReq),
    .frameActive(frameActive), .lockActive(lockActive), .gnt(gnt), .wbGnt(wbGnt)
  );

  task automatic modelReset();
    mGnt = '0; mWb = 1'b0; mOwnV = 1'b0; mOwn = 0;
    mLast = N - 1; mLockPrev = 1'b0; mWbBlk = 1'b0; mTag = "R1";
  endtask

  function automatic int firstIdx(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic modelStep();
    logic [N-1:0] oldGnt;
    logic oldWb;
    logic lockRise;
    oldGnt = mGnt; oldWb = mWb;
    lockRise = lockActive && !mLockPrev;
    if (!rstN) begin
      modelReset();
      return;
    end
    if (!frameActive) begin
      mGnt = '0; mWb = 1'b0;
      if (wbReq && !mWbBlk) begin
        mWb = 1'b1; mTag = "R8";
      end else if (lockMode && mOwnV && lockActive) begin
        mTag = "R6";
        if (req[mOwn]) begin mGnt = N'(1) << mOwn; mLast = mOwn; end
      end else begin
        mTag = lockMode ? "R4" : "R7";
        for (int k = 1; k <= N; k++) begin
          int c;
          c = (mLast + k) % N;
          if (mGnt == '0 && req[c]) begin mGnt = N'(1) << c; mLast = c; end
        end
      end
    end else begin
      mTag = "R3";
    end
    if (!frameActive && !lockActive) mOwnV = 1'b0;
    else if (lockRise && frameActive && oldGnt != '0 && !mOwnV) begin
      mOwnV = 1'b1; mOwn = firstIdx(oldGnt);
    end
    if (!wbReq) mWbBlk = 1'b0;
    else if (oldWb && frameActive) mWbBlk = 1'b1;
    mLockPrev = lockActive;
  endtask

  task automatic check(logic [N-1:0] expG, logic expW, string tag);
    checks++;
    if (gnt !== expG || wbGnt !== expW) begin
      fails++;
      $display("FAIL %s: gnt=%b wbGnt=%b expected gnt=%b wbGnt=%b at %0t",
               tag, gnt, wbGnt, expG, expW, $time);
    end
  endtask

  task automatic tick(logic m, logic [N-1:0] r, logic w, logic f, logic l);
    @(negedge clk);
    lockMode = m; req = r; wbReq = w; frameActive = f; lockActive = l;
    @(posedge clk);
    modelStep();
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #3000000;
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    int seed;
    modelReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check('0, 1'b0, "R1 during reset");
    @(negedge clk); rstN = 1'b1;

    // directed: complete-lock with writeback exception
    tick(1, 4'b0011, 0, 0, 0); check(4'b0001, 0, "R4 first after reset");
    tick(1, 4'b0011, 0, 1, 0); check(4'b0001, 0, "R3 hold busy");
    tick(1, 4'b0011, 0, 1, 1); check(4'b0001, 0, "R5 owner taken");
    tick(1, 4'b1110, 0, 0, 1); check(4'b0000, 0, "R6 non-owners refused");
    tick(1, 4'b1111, 1, 0, 1); check(4'b0000, 1, "R8 writeback under lock");
    tick(1, 4'b1111, 1, 1, 1); check(4'b0000, 1, "R3 writeback held");
    tick(1, 4'b1111, 1, 0, 1); check(4'b0001, 0, "R9 back to owner");
    tick(1, 4'b1110, 0, 0, 0); check(4'b0010, 0, "R10 owner released");
    // ordinary mode ignores lock
    tick(0, 4'b1111, 0, 1, 1); check(4'b0010, 0, "R3 hold");
    tick(0, 4'b1101, 0, 0, 1); check(4'b0100, 0, "R7 lock ignored");
    // lock rising on idle bus gives no ownership
    tick(1, 4'b0000, 0, 0, 0); check(4'b0000, 0, "R4 no request");
    tick(1, 4'b0001, 0, 0, 1); check(4'b0001, 0, "R4 wrap");
    tick(1, 4'b0010, 0, 0, 1); check(4'b0010, 0, "R5 no idle ownership");
    tick(1, 4'b0010, 1, 0, 1); check(4'b0000, 1, "R8 writeback priority");
    tick(1, 4'b0010, 1, 0, 1); check(4'b0000, 1, "R9 unused grant kept");

    // reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); modelStep(); #1;
    check('0, 1'b0, "R1 reset clears");
    @(negedge clk); rstN = 1'b1;

    // random phase against reference model
    seed = $urandom(32'h5eed_1234);
    for (int n = 0; n < 4000; n++) begin
      logic m, w, f, l;
      logic [N-1:0] r;
      m = (n / 500) % 2 == 0;
      r = N'($urandom_range(0, (1 << N) - 1));
      w = ($urandom_range(0, 5) == 0) ? ~wbReq : wbReq;
      f = $urandom_range(0, 1) == 1;
      l = ($urandom_range(0, 7) == 0) ? ~lockActive : lockActive;
      tick(m, r, w, f, l);
      check(mGnt, mWb, {mTag, " random"});
      if (!$onehot0({gnt, wbGnt})) begin
        checks++; fails++;
        $display("FAIL R2: gnt=%b wbGnt=%b expected at most one high", gnt, wbGnt);
      end
    end
    finishRun();
  end
endmodule